// File: doc/BRIEF.md
# Rounded Baud Divisor Calculator

This block turns a peripheral clock frequency in hertz and a requested serial bit rate into the 16-bit fixed-point divisor word that a UART baud generator loads. The word holds an integer part in its upper twelve bits and a fraction below it. With 16x oversampling the fraction has four bits; with 8x oversampling it has three bits and the top fraction bit stays clear. In both modes the scaled divisor equals clock / bit rate, so a single rounded division serves both. Only the packing and the range limits change with the mode.

The quotient is formed as floor((clock + floor(rate/2)) / rate). This gives round-to-nearest on the full remainder instead of truncating at some decimal precision. A restoring shift-subtract divider produces one quotient bit per cycle over a 33-bit dividend, so no carry is lost when the rounding term is added to a full-scale clock. The block flags an error when the rate is zero, when the integer part would be zero, or when the integer part would not fit in twelve bits.

The controller has four states. IDLE waits for `start`. IDLE goes to SHIFT on a start with a nonzero rate, and loads the operands. IDLE goes straight to DONE on a start with a zero rate. SHIFT runs one divider step per cycle and goes to PACK after the last step. PACK registers the packed word and the error flag, then goes to DONE. DONE raises `done` for one cycle and returns to IDLE.

Top module: `baud_div_calc`

## Requirements
- R1: With `over8`=0 and no error, `brr` equals round(pclk_hz / bit_rate). The integer part is in bits [15:4] and the fraction in sixteenths is in bits [3:0]. Examples: 72 MHz at 9600 gives 0x1D4C, 36 MHz at 9600 gives 0x0EA6, 24 MHz at 19200 gives 0x04E2, and 24 MHz at 921600 gives 0x001A.
- R2: The fraction is rounded to nearest using the whole remainder. 72 MHz at 19207 gives 0x0EA5 (fraction 5, not 4).
- R3: With `over8`=1 and no error, let q = round(pclk_hz / bit_rate). Then bits [15:4] hold q>>3, bits [2:0] hold q&7, and bit 3 is 0. Example: 12 MHz at 460800 gives 0x0032.
- R4: A start with `bit_rate`=0 sets `err`=1 and `brr`=0, and `done` rises on the cycle after the start is accepted.
- R5: If the integer part is zero, `err`=1 and `brr`=0. This happens for q<16 with `over8`=0 and for q<8 with `over8`=1. q=16 (mode 0) and q=8 (mode 1, giving 0x0010) are accepted.
- R6: If the integer part exceeds 4095, `err`=1 and `brr`=0. This happens for q>65535 (mode 0) and q>32767 (mode 1). q=65535 gives 0xFFFF and q=32767 gives 0xFFF7.
- R7: For a nonzero rate, `done` is a one-cycle pulse that appears 35 clock edges after the accepting edge, counting that edge as the first. `busy` is 1 from the accepting edge until `done`.
- R8: A `start` while `busy` is ignored. The operands are sampled only at the accepting edge, and exactly one `done` follows each accepted start.
- R9: After reset, `busy`, `done`, `err` and `brr` are all 0. `brr` and `err` hold their values until the next result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a calculation (accepted in IDLE) |
| pclk_hz | input | 32 | Peripheral clock frequency in Hz |
| bit_rate | input | 32 | Requested bit rate |
| over8 | input | 1 | 1 selects 8x oversampling packing, 0 selects 16x |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle result strobe |
| brr | output | 16 | Packed divisor word |
| err | output | 1 | Zero rate or integer part out of range |

## Verification
The bench builds the block with its default parameters: 32-bit clock and rate operands, a 16-bit word and a 4-bit fraction. This gives a 33-bit dividend and a 35-cycle latency. With these sizes, full-scale 32-bit operands can be applied to exercise the carry out of the rounding addition. Both ends of the 12-bit integer range can be reached in each oversampling mode with small clock and rate values, next to the known divisor examples.

// File: rtl/baud_calc_pkg.sv
package baud_calc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_PACK  = 2'd2,
        ST_DONE  = 2'd3
    } calc_state_t;
endpackage

// File: rtl/baud_shift_div.sv
// Restoring divider: one quotient bit per step, quotient shifts into the
// dividend register as the dividend shifts out.
module baud_shift_div #(
    parameter int NUM_W = 33,
    parameter int DEN_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [NUM_W-1:0] numer,
    input  logic [DEN_W-1:0] denom,
    output logic [NUM_W-1:0] quot
);
    logic [NUM_W-1:0] work_q;
    logic [DEN_W-1:0] rem_q;
    logic [DEN_W-1:0] den_q;
    logic [DEN_W:0]   trial;
    logic [DEN_W:0]   diff;
    logic             fits;

    always_comb begin
        trial = {rem_q, work_q[NUM_W-1]};
        diff  = trial - {1'b0, den_q};
        fits  = (trial >= {1'b0, den_q});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            work_q <= '0;
            rem_q  <= '0;
            den_q  <= '0;
        end else if (load) begin
            work_q <= numer;
            rem_q  <= '0;
            den_q  <= denom;
        end else if (step) begin
            rem_q  <= fits ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
            work_q <= {work_q[NUM_W-2:0], fits};
        end
    end

    assign quot = work_q;

    // the partial remainder never reaches the divisor (rounding for R1)
    assert_rem_below_div_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (step && den_q != '0) |=> (rem_q < den_q));
endmodule

// File: rtl/baud_field_pack.sv
// Splits the rounded quotient into integer and fraction fields per mode
// and range-checks the integer part.
module baud_field_pack #(
    parameter int Q_W    = 33,
    parameter int BRR_W  = 16,
    parameter int FRAC_W = 4
) (
    input  logic [Q_W-1:0]   quot,
    input  logic             mode8,
    output logic [BRR_W-1:0] word,
    output logic             range_err
);
    localparam int INT_W = BRR_W - FRAC_W;
    localparam logic [Q_W-1:0] INT_MAX = {{(Q_W-INT_W){1'b0}}, {INT_W{1'b1}}};

    logic [Q_W-1:0]    int_full;
    logic [FRAC_W-1:0] frac;

    always_comb begin
        if (mode8) begin
            int_full = quot >> (FRAC_W - 1);
            frac     = {1'b0, quot[FRAC_W-2:0]};
        end else begin
            int_full = quot >> FRAC_W;
            frac     = quot[FRAC_W-1:0];
        end
        range_err = (int_full == '0) || (int_full > INT_MAX);
        word      = range_err ? '0 : {int_full[INT_W-1:0], frac};
    end
endmodule

// File: rtl/baud_div_calc.sv
module baud_div_calc #(
    parameter int CLK_W  = 32,
    parameter int BAUD_W = 32,
    parameter int BRR_W  = 16,
    parameter int FRAC_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CLK_W-1:0]  pclk_hz,
    input  logic [BAUD_W-1:0] bit_rate,
    input  logic              over8,
    output logic              busy,
    output logic              done,
    output logic [BRR_W-1:0]  brr,
    output logic              err
);
    import baud_calc_pkg::*;

    localparam int NUM_W = CLK_W + 1;
    localparam int CNT_W = $clog2(NUM_W + 1);
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(NUM_W - 1);

    calc_state_t       state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic              mode8_q;
    logic [BRR_W-1:0]  brr_q;
    logic              err_q;
    logic              accept, zero_rate, load, step;
    logic [NUM_W-1:0]  dividend;
    logic [NUM_W-1:0]  quot;
    logic [BRR_W-1:0]  packed_word;
    logic              range_err;

    assign accept    = (state_q == ST_IDLE) && start;
    assign zero_rate = (bit_rate == '0);
    assign load      = accept && !zero_rate;
    assign step      = (state_q == ST_SHIFT);
    assign dividend  = {1'b0, pclk_hz} + NUM_W'(bit_rate >> 1);

    baud_shift_div #(.NUM_W(NUM_W), .DEN_W(BAUD_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .step  (step),
        .numer (dividend),
        .denom (bit_rate),
        .quot  (quot)
    );

    baud_field_pack #(.Q_W(NUM_W), .BRR_W(BRR_W), .FRAC_W(FRAC_W)) u_pack (
        .quot      (quot),
        .mode8     (mode8_q),
        .word      (packed_word),
        .range_err (range_err)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = zero_rate ? ST_DONE : ST_SHIFT;
            ST_SHIFT: if (cnt_q == '0) state_d = ST_PACK;
            ST_PACK:  state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            mode8_q <= 1'b0;
            brr_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            if (accept) begin
                cnt_q   <= LAST_STEP;
                mode8_q <= over8;
                if (zero_rate) begin
                    brr_q <= '0;
                    err_q <= 1'b1;
                end
            end else if (step) begin
                cnt_q <= cnt_q - 1'b1;
            end
            if (state_q == ST_PACK) begin
                brr_q <= packed_word;
                err_q <= range_err;
            end
        end
    end

    // outputs
    always_comb begin
        busy = (state_q == ST_SHIFT) || (state_q == ST_PACK);
        done = (state_q == ST_DONE);
        brr  = brr_q;
        err  = err_q;
    end

    // latency monitor for the assertion below
    logic [CNT_W-1:0] shift_seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    shift_seen_q <= '0;
        else if (accept)               shift_seen_q <= '0;
        else if (state_q == ST_SHIFT)  shift_seen_q <= shift_seen_q + 1'b1;
    end

    assert_shift_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PACK) |-> (shift_seen_q == CNT_W'(NUM_W)));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_zero_rate_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && zero_rate) |=> (done && err && brr == '0));

    assert_frac_top_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && mode8_q && !err) |-> !brr[FRAC_W-1]);

    assert_ignore_busy_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (busy || done));

    assert_err_clears_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> (brr == '0));
endmodule

// File: tb/tb_baud_div_calc.sv
`timescale 1ns/1ps
module tb_baud_div_calc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] pclk_hz = '0;
    logic [31:0] bit_rate = '0;
    logic        over8 = 1'b0;
    logic        busy, done, err;
    logic [15:0] brr;

    int tests = 0;
    int fails = 0;
    int wd_cycles = 0;

    logic [16:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    baud_div_calc dut (
        .clk(clk), .rst_n(rst_n), .start(start), .pclk_hz(pclk_hz),
        .bit_rate(bit_rate), .over8(over8), .busy(busy), .done(done),
        .brr(brr), .err(err)
    );

    function automatic logic [16:0] model(input logic [31:0] c, input logic [31:0] b, input bit o8);
        logic [63:0] q, ip;
        if (b == 0) return {1'b1, 16'h0};
        q  = (64'(c) + 64'(b / 2)) / 64'(b);
        ip = o8 ? (q >> 3) : (q >> 4);
        if (ip == 0 || ip > 4095) return {1'b1, 16'h0};
        if (o8) return {1'b0, ip[11:0], 1'b0, q[2:0]};
        return {1'b0, ip[11:0], q[3:0]};
    endfunction

    // monitor: pops an expected item at every result strobe
    always @(negedge clk) begin
        if (rst_n && done) begin
            logic [16:0] e;
            string t;
            tests++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R8 unexpected done: got err=%0b brr=%h expected no result", err, brr);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if ({err, brr} !== e) begin
                    fails++;
                    $display("FAIL %s: got err=%0b brr=%h expected err=%0b brr=%h", t, err, brr, e[16], e[15:0]);
                end
            end
        end
    end

    task automatic run_case(input logic [31:0] c, input logic [31:0] b, input bit o8, input string tag);
        int cycles;
        int want;
        exp_q.push_back(model(c, b, o8));
        tag_q.push_back(tag);
        @(negedge clk);
        pclk_hz = c; bit_rate = b; over8 = o8; start = 1'b1;
        @(posedge clk);
        cycles = 1;
        @(negedge clk);
        start = 1'b0;
        if (b != 0) begin
            tests++;
            if (!busy) begin
                fails++;
                $display("FAIL R7 busy after accept: got %0b expected 1", busy);
            end
        end
        while (!done && cycles < 200) begin
            @(posedge clk);
            cycles++;
            @(negedge clk);
        end
        want = (b == 0) ? 1 : 35;
        tests++;
        if (cycles != want) begin
            fails++;
            $display("FAIL %s latency (R7/R4): got %0d expected %0d", tag, cycles, want);
        end
        @(negedge clk);
    endtask

    initial begin : watchdog
        while (wd_cycles < 100000) begin
            @(posedge clk);
            wd_cycles++;
        end
        fails++;
        tests++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        tests++;
        if (busy !== 1'b0 || done !== 1'b0 || err !== 1'b0 || brr !== 16'h0) begin
            fails++;
            $display("FAIL R9 reset: got busy=%0b done=%0b err=%0b brr=%h expected 0 0 0 0000", busy, done, err, brr);
        end
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        run_case(32'd72000000, 32'd9600,   1'b0, "R1 72M/9600");
        run_case(32'd36000000, 32'd9600,   1'b0, "R1 36M/9600");
        run_case(32'd24000000, 32'd19200,  1'b0, "R1 24M/19200");
        run_case(32'd24000000, 32'd921600, 1'b0, "R1 24M/921600");
        run_case(32'd72000000, 32'd19207,  1'b0, "R2 round 19207");
        run_case(32'd72000000, 32'd19207,  1'b1, "R2 round mode8");
        run_case(32'd12000000, 32'd460800, 1'b1, "R3 12M/460800");
        run_case(32'd32000000, 32'd2000000,1'b1, "R3 32M/2M");
        run_case(32'd24000000, 32'd0,      1'b0, "R4 zero rate");
        run_case(32'd24000000, 32'd3000000,1'b0, "R5 int zero mode0");
        run_case(32'd24000000, 32'd1500000,1'b0, "R5 q=16 mode0");
        run_case(32'd24000000, 32'd3000000,1'b1, "R5 q=8 mode8");
        run_case(32'd7000000,  32'd1000000,1'b1, "R5 q=7 mode8");
        run_case(32'd65535,    32'd1,      1'b0, "R6 q=65535");
        run_case(32'd65536,    32'd1,      1'b0, "R6 q=65536");
        run_case(32'd32767,    32'd1,      1'b1, "R6 q=32767 mode8");
        run_case(32'd32768,    32'd1,      1'b1, "R6 q=32768 mode8");
        run_case(32'd72000000, 32'd1000,   1'b0, "R6 overflow");
        run_case(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R5 full scale");
        run_case(32'hFFFF_FFFF, 32'h0010_0000, 1'b1, "R6 carry overflow");

        // R8: extra starts while busy carry other operands and must be ignored
        exp_q.push_back(model(32'd24000000, 32'd19200, 1'b0));
        tag_q.push_back("R8 ignore busy start");
        @(negedge clk);
        pclk_hz = 32'd24000000; bit_rate = 32'd19200; over8 = 1'b0; start = 1'b1;
        @(negedge clk);
        pclk_hz = 32'd72000000; bit_rate = 32'd9600; over8 = 1'b1;
        repeat (5) @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        repeat (45) begin
            @(negedge clk);
            tests++;
            if (busy || done) begin
                fails++;
                $display("FAIL R8 second run: got busy=%0b done=%0b expected 0 0", busy, done);
            end
        end
        tests++;
        if (brr !== 16'h04E2) begin
            fails++;
            $display("FAIL R9 hold: got brr=%h expected 04e2", brr);
        end
        tests++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R8 pending results: got %0d expected 0", exp_q.size());
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule